// File: doc/BRIEF.md
# External Master Address Bridge

This block lets a master sitting outside the chip reach on-chip slaves through a narrow 24-bit external address bus. Each transfer is a single read or write. The most significant external address bit says whether the access is meant for this chip at all. When that bit is clear, the access belongs to some other device on the shared bus. The bridge then stays completely passive: it neither answers nor drives data.

When the bit is set, the next three bits form a slave code. The code indexes an eight-entry remap table, which is a parameter. A valid entry supplies the top eight bits of the 32-bit internal address and the four bits that follow them. The low twenty external bits pass through unchanged. The bridge raises a request to the selected internal slave and holds it until the slave acknowledges. It then returns a one-cycle acknowledge to the external master, together with the read data on a read.

The following cases all end in a one-cycle bus error and never reach an internal slave:
- an unmapped code, including the code reserved for the calibration region;
- a burst request;
- an unsupported size code.

Top module: `ext_addr_bridge`

## Requirements
- R1: After reset, ext_ack_o, ext_err_o, ext_rdata_oe_o and int_req_o are low, int_sel_o is zero and ext_rdata_o is zero.
- R2: A strobe with ext_addr_i[23] = 0 is ignored. No acknowledge, no error, no internal request and no read-data drive follow it.
- R3: With ext_addr_i[23] = 1, the code ext_addr_i[22:20] selects a remap entry. The default table maps code 0 to upper 8'hC3 and middle 4'hF, code 1 to 8'h40 and 4'h0, code 2 to 8'h00 and 4'h0, and code 3 to 8'hFF and 4'hF. The internal address is {upper, middle, ext_addr_i[19:0]}, and int_sel_o has only bit <code> set while the request is active.
- R4: Codes 4 to 7 are invalid; code 4 is the calibration region. An on-chip access using one of them ends in ext_err_o and raises no internal request.
- R5: Size codes are 00 = 8 bits, 01 = 16 bits and 10 = 32 bits. An on-chip access with size 11 or with ext_burst_i high ends in ext_err_o and is not forwarded.
- R6: int_req_o rises in the second cycle after the strobe edge. It stays high, with int_addr_o stable, until the edge at which int_ack_i is sampled high.
- R7: On a read, ext_ack_o and ext_rdata_oe_o are high for the one cycle after int_ack_i is sampled. During that cycle ext_rdata_o carries the int_rdata_i value sampled at that edge. On a write, ext_rdata_oe_o stays low.
- R8: Write data, direction and size are registered at the strobe edge. Later changes on ext_wdata_i do not alter int_wdata_o.
- R9: An error is signalled in the second cycle after the strobe edge. ext_ack_o and ext_err_o are each one cycle long and never high together.
- R10: Strobes that arrive while an access is in progress are ignored. They change neither int_addr_o nor the response, and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | One-cycle access strobe from the external master |
| ext_addr_i | input | 24 | External address, bit 23 = on-chip flag |
| ext_we_i | input | 1 | 1 = write, 0 = read |
| ext_size_i | input | 2 | Transfer size code |
| ext_burst_i | input | 1 | Burst indication (always rejected) |
| ext_wdata_i | input | 32 | Write data from the external master |
| ext_rdata_o | output | 32 | Read data returned to the external master |
| ext_rdata_oe_o | output | 1 | Read-data drive enable |
| ext_ack_o | output | 1 | Transfer acknowledge, one cycle |
| ext_err_o | output | 1 | Bus error, one cycle |
| int_req_o | output | 1 | Internal request, held until acknowledged |
| int_sel_o | output | 8 | One-hot internal slave select |
| int_addr_o | output | 32 | Rebuilt internal address |
| int_we_o | output | 1 | Internal write enable |
| int_size_o | output | 2 | Internal transfer size |
| int_wdata_o | output | 32 | Internal write data |
| int_ack_i | input | 1 | Internal slave acknowledge |
| int_rdata_i | input | 32 | Internal slave read data |

## Verification
The hardest situation to reach is a second strobe that lands while an access is already waiting on a slow internal slave. It is only visible if the slave keeps the request open long enough. The bench plays the slave itself and withholds int_ack_i for several cycles. In that window it fires a strobe to a different code, then confirms that the forwarded address and the single response are unaffected. A full sweep over every code, size, burst flag and direction, with varying slave latency, covers the remap table and every error cause.

// File: rtl/ext_bridge_pkg.sv
package ext_bridge_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int UPPER_W   = 8;
  localparam int MID_W     = 4;

  typedef struct packed {
    logic               valid;
    logic [UPPER_W-1:0] upper;
    logic [MID_W-1:0]   mid;
  } remap_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_FORWARD,
    ST_RESPOND
  } bridge_state_e;

  // entry 7 leftmost; code 4 is the unreachable calibration region
  localparam remap_t [NUM_CODES-1:0] DEFAULT_REMAP = {
    {1'b0, 8'h00, 4'h0},
    {1'b0, 8'h00, 4'h0},
    {1'b0, 8'h00, 4'h0},
    {1'b0, 8'h00, 4'h0},
    {1'b1, 8'hFF, 4'hF},
    {1'b1, 8'h00, 4'h0},
    {1'b1, 8'h40, 4'h0},
    {1'b1, 8'hC3, 4'hF}
  };
endpackage

// File: rtl/ext_bridge_decode.sv
module ext_bridge_decode
  import ext_bridge_pkg::*;
#(
  parameter int EXT_AW = 24,
  parameter int INT_AW = 32,
  parameter remap_t [NUM_CODES-1:0] REMAP = DEFAULT_REMAP
) (
  input  logic [EXT_AW-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic                 burst_i,
  output logic                 onchip_o,
  output logic                 err_o,
  output logic [NUM_CODES-1:0] sel_o,
  output logic [INT_AW-1:0]    int_addr_o
);
  localparam int PASS_W = EXT_AW - 1 - CODE_W;

  logic [CODE_W-1:0]    code;
  logic [PASS_W-1:0]    pass;
  logic [NUM_CODES-1:0] hit;
  logic                 fmt_err;
  remap_t               entry;

  assign onchip_o = addr_i[EXT_AW-1];
  assign code     = addr_i[EXT_AW-2 -: CODE_W];
  assign pass     = addr_i[PASS_W-1:0];
  assign fmt_err  = burst_i || (size_i == SZ_BAD);

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_hit
    if (REMAP[g].valid) begin : g_live
      assign hit[g] = onchip_o && (code == CODE_W'(g));
    end else begin : g_dead
      assign hit[g] = 1'b0;
    end
  end

  assign sel_o      = fmt_err ? '0 : hit;
  assign err_o      = onchip_o && (fmt_err || !(|hit));
  assign entry      = REMAP[code];
  assign int_addr_o = {entry.upper, entry.mid, pass};
endmodule

// File: rtl/ext_bridge_fsm.sv
module ext_bridge_fsm
  import ext_bridge_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dec_err_i,
  input  logic          int_ack_i,
  output bridge_state_e state_o,
  output logic          load_o,
  output logic          rcap_o,
  output logic          int_req_o,
  output logic          ack_o,
  output logic          err_o
);
  bridge_state_e state_q, state_d;
  logic          err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_DECODE;
      ST_DECODE:  state_d = dec_err_i ? ST_RESPOND : ST_FORWARD;
      ST_FORWARD: if (int_ack_i) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) err_q <= dec_err_i;
    end
  end

  assign state_o   = state_q;
  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign rcap_o    = (state_q == ST_FORWARD) && int_ack_i;
  assign int_req_o = (state_q == ST_FORWARD);
  assign ack_o     = (state_q == ST_RESPOND) && !err_q;
  assign err_o     = (state_q == ST_RESPOND) && err_q;

  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_o && !int_ack_i) |=> int_req_o);
  a_r5_err_skips_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && dec_err_i) |=> (err_o && !int_req_o));
  a_r9_resp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_o, err_o}));
  a_r9_resp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || err_o) |=> !(ack_o || err_o));
endmodule

// File: rtl/ext_bridge_dp.sv
module ext_bridge_dp #(
  parameter int EXT_AW = 24,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rcap_i,
  input  logic [EXT_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              burst_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rdata_i,
  output logic [EXT_AW-1:0] addr_o,
  output logic              we_o,
  output logic [1:0]        size_o,
  output logic              burst_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      we_o    <= 1'b0;
      size_o  <= '0;
      burst_o <= 1'b0;
      wdata_o <= '0;
    end else if (load_i) begin
      addr_o  <= addr_i;
      we_o    <= we_i;
      size_o  <= size_i;
      burst_o <= burst_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rcap_i) rdata_o <= rdata_i;
  end
endmodule

// File: rtl/ext_addr_bridge.sv
module ext_addr_bridge
  import ext_bridge_pkg::*;
#(
  parameter int EXT_AW = 24,
  parameter int INT_AW = 32,
  parameter int DW     = 32,
  parameter remap_t [NUM_CODES-1:0] REMAP = DEFAULT_REMAP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_req_i,
  input  logic [EXT_AW-1:0]    ext_addr_i,
  input  logic                 ext_we_i,
  input  logic [1:0]           ext_size_i,
  input  logic                 ext_burst_i,
  input  logic [DW-1:0]        ext_wdata_i,
  output logic [DW-1:0]        ext_rdata_o,
  output logic                 ext_rdata_oe_o,
  output logic                 ext_ack_o,
  output logic                 ext_err_o,
  output logic                 int_req_o,
  output logic [NUM_CODES-1:0] int_sel_o,
  output logic [INT_AW-1:0]    int_addr_o,
  output logic                 int_we_o,
  output logic [1:0]           int_size_o,
  output logic [DW-1:0]        int_wdata_o,
  input  logic                 int_ack_i,
  input  logic [DW-1:0]        int_rdata_i
);
  bridge_state_e        state;
  logic                 load, rcap, start;
  logic                 onchip, dec_err;
  logic                 burst_q;
  logic [EXT_AW-1:0]    addr_q;
  logic [DW-1:0]        rdata_q;
  logic [NUM_CODES-1:0] sel;

  assign start = ext_req_i && ext_addr_i[EXT_AW-1];

  ext_bridge_dp #(.EXT_AW(EXT_AW), .DW(DW)) u_dp (
    .clk_i, .rst_ni,
    .load_i (load),
    .rcap_i (rcap),
    .addr_i (ext_addr_i),
    .we_i   (ext_we_i),
    .size_i (ext_size_i),
    .burst_i(ext_burst_i),
    .wdata_i(ext_wdata_i),
    .rdata_i(int_rdata_i),
    .addr_o (addr_q),
    .we_o   (int_we_o),
    .size_o (int_size_o),
    .burst_o(burst_q),
    .wdata_o(int_wdata_o),
    .rdata_o(rdata_q)
  );

  ext_bridge_decode #(.EXT_AW(EXT_AW), .INT_AW(INT_AW), .REMAP(REMAP)) u_dec (
    .addr_i    (addr_q),
    .size_i    (int_size_o),
    .burst_i   (burst_q),
    .onchip_o  (onchip),
    .err_o     (dec_err),
    .sel_o     (sel),
    .int_addr_o(int_addr_o)
  );

  ext_bridge_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i  (start),
    .dec_err_i(dec_err || !onchip),
    .int_ack_i,
    .state_o  (state),
    .load_o   (load),
    .rcap_o   (rcap),
    .int_req_o(int_req_o),
    .ack_o    (ext_ack_o),
    .err_o    (ext_err_o)
  );

  assign int_sel_o      = int_req_o ? sel : '0;
  assign ext_rdata_oe_o = ext_ack_o && !int_we_o;
  assign ext_rdata_o    = ext_rdata_oe_o ? rdata_q : '0;

  a_r2_offchip_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && ext_req_i && !ext_addr_i[EXT_AW-1]) |=> (state == ST_IDLE));
  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_o && !int_ack_i) |=> $stable(int_addr_o));
  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_req_o |-> $onehot(int_sel_o));
  a_r10_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && ext_req_i) |=> $stable(addr_q));
endmodule

// File: tb/tb_ext_addr_bridge.sv
module tb_ext_addr_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_req = 1'b0;
  logic [23:0] ext_addr = '0;
  logic        ext_we = 1'b0;
  logic [1:0]  ext_size = '0;
  logic        ext_burst = 1'b0;
  logic [31:0] ext_wdata = '0;
  logic [31:0] ext_rdata;
  logic        ext_oe, ext_ack, ext_err;
  logic        int_req;
  logic [7:0]  int_sel;
  logic [31:0] int_addr;
  logic        int_we;
  logic [1:0]  int_size;
  logic [31:0] int_wdata;
  logic        int_ack = 1'b0;
  logic [31:0] int_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_addr_bridge dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ext_req_i(ext_req), .ext_addr_i(ext_addr), .ext_we_i(ext_we),
    .ext_size_i(ext_size), .ext_burst_i(ext_burst), .ext_wdata_i(ext_wdata),
    .ext_rdata_o(ext_rdata), .ext_rdata_oe_o(ext_oe),
    .ext_ack_o(ext_ack), .ext_err_o(ext_err),
    .int_req_o(int_req), .int_sel_o(int_sel), .int_addr_o(int_addr),
    .int_we_o(int_we), .int_size_o(int_size), .int_wdata_o(int_wdata),
    .int_ack_i(int_ack), .int_rdata_i(int_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic bit exp_valid(input logic [2:0] c);
    return c < 3'd4;
  endfunction

  function automatic logic [11:0] exp_top(input logic [2:0] c);
    case (c)
      3'd0:    return 12'hC3F;
      3'd1:    return 12'h400;
      3'd2:    return 12'h000;
      default: return 12'hFFF;
    endcase
  endfunction

  task automatic silent(input string req);
    chk(!ext_ack && !ext_err && !int_req && !ext_oe && int_sel == 0, req,
        {ext_ack, ext_err, int_req, ext_oe}, 0);
  endtask

  task automatic access(input logic [2:0] code, input logic [19:0] low, input logic we,
                        input logic [1:0] sz, input logic bst, input int lat);
    logic [31:0] wd, rd, ea;
    bit          bad;
    bad = !exp_valid(code) || bst || (sz == 2'b11);
    wd  = {12'hA5C, low};
    ea  = {exp_top(code), low};
    rd  = {low[15:0] ^ 16'h5A5A, 13'h0, code};
    @(negedge clk);
    ext_req = 1; ext_addr = {1'b1, code, low}; ext_we = we; ext_size = sz;
    ext_burst = bst; ext_wdata = wd;
    @(negedge clk);
    ext_req = 0; ext_wdata = ~wd;
    silent("R6 decode cycle");
    @(negedge clk);
    if (bad) begin
      chk(ext_err && !ext_ack, bst || sz == 2'b11 ? "R5 format error" : "R4 invalid code",
          {ext_ack, ext_err}, 2'b01);
      chk(!int_req && int_sel == 0 && !ext_oe, "R4 R5 no forward", {int_req, int_sel}, 0);
      @(negedge clk);
      silent("R9 error one cycle");
    end else begin
      chk(int_req && !ext_ack && !ext_err, "R6 request raised", int_req, 1);
      chk(int_addr == ea, "R3 internal address", int_addr, ea);
      chk(int_sel == 8'(1 << code), "R3 slave select", int_sel, 8'(1 << code));
      chk(int_wdata == wd && int_we == we && int_size == sz, "R8 registered write side",
          {int_wdata, int_we, int_size}, {wd, we, sz});
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(int_req && !ext_ack && int_addr == ea, "R6 request held", {int_req, int_addr}, {1'b1, ea});
      end
      int_ack = 1; int_rdata = rd;
      @(negedge clk);
      int_ack = 0; int_rdata = 32'hDEAD_BEEF;
      chk(ext_ack && !ext_err && !int_req, "R9 acknowledge", {ext_ack, ext_err, int_req}, 3'b100);
      if (!we) chk(ext_oe && ext_rdata == rd, "R7 read data", ext_rdata, rd);
      else     chk(!ext_oe, "R7 no drive on write", ext_oe, 0);
      @(negedge clk);
      silent("R9 acknowledge one cycle");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    silent("R1 reset state");
    chk(ext_rdata == 0, "R1 rdata zero", ext_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    silent("R1 after release");

    // R2 off-chip strobes
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ext_req = 1; ext_addr = {1'b0, 3'(k * 3), 20'(k * 20'h1111)}; ext_we = k[0];
      ext_size = 2'(k); ext_burst = k[1];
      @(negedge clk);
      ext_req = 0;
      for (int j = 0; j < 4; j++) begin
        silent("R2 off-chip ignored");
        @(negedge clk);
      end
    end

    // sweep: codes R3 R4, sizes/burst R5, directions R7 R8
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 2; b++)
          for (int w = 0; w < 2; w++)
            access(3'(c), {3'(c), 2'(s), 1'(b), 1'(w), 13'(c * 37 + s * 11 + 5)},
                   1'(w), 2'(s), 1'(b), (c + s) % 3);

    // R10 strobe while busy
    @(negedge clk);
    ext_req = 1; ext_addr = {1'b1, 3'd0, 20'h0ABCD}; ext_we = 0; ext_size = 2'b10;
    ext_burst = 0;
    @(negedge clk);
    ext_req = 0;
    @(negedge clk);
    chk(int_req, "R10 first access forwarded", int_req, 1);
    ext_req = 1; ext_addr = {1'b1, 3'd1, 20'h11111}; ext_we = 1;
    @(negedge clk);
    ext_req = 0;
    repeat (2) @(negedge clk);
    chk(int_addr == 32'hC3F0ABCD && int_sel == 8'h01 && !int_we, "R10 busy strobe ignored",
        int_addr, 32'hC3F0ABCD);
    int_ack = 1; int_rdata = 32'h1234_5678;
    @(negedge clk);
    int_ack = 0;
    chk(ext_ack && ext_rdata == 32'h1234_5678, "R10 single response", ext_rdata, 32'h1234_5678);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      silent("R10 no extra access");
    end

    finish_run();
  end
endmodule